// File: doc/BRIEF.md
# Serial Memory Command Front-End

This block is the slave-side command engine of a byte-wide serial memory. The bus master drives chip select, serial clock, serial data in and a hold line. The block runs on its own system clock and oversamples those pins. It shifts in an 8-bit command code, MSB first, on each rising clock edge. For array commands it then collects a 16-bit address. After that it streams bytes between the serial bus and a small synchronous memory port, or a status/program controller.

Reads prefetch through the memory port so that each byte is ready before its first bit is due. Serial output changes only after a falling serial clock edge, and it is driven only while a byte is actually being sent out. Writes are forwarded byte by byte, and their address wraps inside a fixed-size page. Status read and status write go to the controller. The block sends write-enable and write-disable commands to the controller as one-cycle strobes.

A busy flag from the controller locks out every command except status read. Unknown command codes silence the rest of the frame. A hold input freezes the bit position mid-frame.

Top module: `spi_mem_frontend`

## Requirements
- R1: After reset, and with no frame in progress, soOe is low and memReq, wrenStb, wrdiStb and statWrStb are all low.
- R2: Serial input is sampled on rising serial clock edges, MSB first. The command byte decodes with bit 3 ignored: 0000_x011 read, 0000_x010 write, 0000_x110 write-enable, 0000_x100 write-disable, 0000_x101 status read, 0000_x001 status write.
- R3: Any other command byte makes the block ignore the rest of the frame. No strobe fires, no memory request is made, soOe stays low, and a new command is taken only after csN goes high and low again.
- R4: While csN is high, soOe is low and serial input has no effect. Raising csN mid-frame abandons the frame, and the next frame starts again at the command byte.
- R5: Read and write take a 16-bit address, MSB first. Only its low ADDR_BITS bits select the memory location.
- R6: In a read, the MSB of the first data byte is on so, with soOe high, after the falling edge that follows the last address bit. Later bits follow MSB first, one per falling edge.
- R7: A read streams consecutive bytes, incrementing the address after each byte. After the highest address it wraps to address 0.
- R8: In a write, each complete data byte gives exactly one memory write, with memWe high, at the current address. The address then advances within its aligned page of PAGE_BYTES bytes and wraps to the start of that page.
- R9: Write-enable and write-disable each give a single one-cycle pulse on wrenStb or wrdiStb.
- R10: Status read returns statRdata on so, repeated for each byte clocked. Status write passes its single data byte to wrData with a one-cycle statWrStb pulse.
- R11: While busy is high when the command byte completes, only status read is accepted, and it returns 0xFF. Every other command behaves as in R3.
- R12: The hold state is entered when holdN goes low while sck is low, and left when holdN goes high while sck is low. While held, serial clock edges are ignored and soOe is low. The transfer resumes from the same bit.
- R13: During a read, serial input after the last address bit causes no write and no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock from the master |
| si | input | 1 | Serial data in |
| holdN | input | 1 | Hold request, active low |
| so | output | 1 | Serial data out, high impedance when not enabled |
| soOe | output | 1 | Output enable for so |
| busy | input | 1 | Programming cycle in progress |
| statRdata | input | 8 | Status byte from the controller |
| wrenStb | output | 1 | Write-enable command pulse |
| wrdiStb | output | 1 | Write-disable command pulse |
| statWrStb | output | 1 | Status-write pulse, data on wrData |
| memReq | output | 1 | Memory port request |
| memWe | output | 1 | Memory port write enable |
| memAddr | output | ADDR_BITS | Memory port address |
| wrData | output | 8 | Write byte for memory or status |
| memRdata | input | 8 | Memory read data, valid the cycle after a read request |

## Verification
The bench builds the block with ADDR_BITS of 6 and PAGE_BYTES of 4. With these values, the wrap of a read from the top address back to 0 and the wrap of a write inside its page both happen after only a few bytes. The 16-bit addresses it sends carry set upper bits, which must be dropped. A bench-side memory and an expected-event queue track every write, strobe and status byte. Holds are placed both inside a read byte and inside a write byte.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;

  typedef enum logic [2:0] {
    PH_OPC,
    PH_ADDR,
    PH_WDATA,
    PH_RDATA,
    PH_SWR,
    PH_SRD,
    PH_SKIP
  } phase_t;

  typedef enum logic [2:0] {
    CMD_BAD,
    CMD_RD,
    CMD_WR,
    CMD_WEN,
    CMD_WDIS,
    CMD_SRD,
    CMD_SWR
  } cmd_t;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftIn;
    logic addrShift;
    logic capWr;
    logic outLoad;
    logic outShift;
    logic srcStat;
    logic addrIncRd;
    logic addrIncPg;
  } strobe_t;

  function automatic cmd_t decodeCmd(input logic [7:0] op);
    cmd_t c;
    c = CMD_BAD;
    if (op[7:4] == 4'h0) begin
      case (op[2:0])
        3'b011:  c = CMD_RD;
        3'b010:  c = CMD_WR;
        3'b110:  c = CMD_WEN;
        3'b100:  c = CMD_WDIS;
        3'b101:  c = CMD_SRD;
        3'b001:  c = CMD_SWR;
        default: c = CMD_BAD;
      endcase
    end
    return c;
  endfunction

endpackage

// File: rtl/spi_fe_ctrl.sv
module spi_fe_ctrl
  import spi_fe_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       sck,
  input  logic       holdN,
  input  logic       busy,
  input  logic [7:0] rxNext,
  output strobe_t    stb,
  output logic       soOe,
  output logic       wrenStb,
  output logic       wrdiStb,
  output logic       statWrStb,
  output logic       memReq,
  output logic       memWe
);

  logic   sckQ;
  logic   held;
  logic   outActive;
  logic   isRead;
  phase_t phase;
  logic [3:0] bitCnt;
  logic   rise;
  logic   fall;
  cmd_t   cmd;
  logic   byteEnd;

  assign rise    = sck & ~sckQ & ~held & ~csN;
  assign fall    = ~sck & sckQ & ~held & ~csN;
  assign cmd     = decodeCmd(rxNext);
  assign byteEnd = (bitCnt == 4'd7);
  assign soOe    = outActive & ~held & ~csN;

  always_comb begin
    stb = '0;
    if (rise) begin
      case (phase)
        PH_OPC:   stb.shiftIn = 1'b1;
        PH_ADDR: begin
          stb.shiftIn   = 1'b1;
          stb.addrShift = 1'b1;
        end
        PH_WDATA, PH_SWR: begin
          stb.shiftIn = 1'b1;
          stb.capWr   = byteEnd;
        end
        default: ;
      endcase
    end
    if (fall && (phase == PH_RDATA || phase == PH_SRD)) begin
      if (bitCnt == 4'd0) begin
        stb.outLoad   = 1'b1;
        stb.srcStat   = (phase == PH_SRD);
        stb.addrIncRd = (phase == PH_RDATA);
      end else begin
        stb.outShift = 1'b1;
      end
    end
    stb.addrIncPg = memReq & memWe;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckQ      <= 1'b0;
      held      <= 1'b0;
      phase     <= PH_OPC;
      bitCnt    <= '0;
      outActive <= 1'b0;
      isRead    <= 1'b0;
      wrenStb   <= 1'b0;
      wrdiStb   <= 1'b0;
      statWrStb <= 1'b0;
      memReq    <= 1'b0;
      memWe     <= 1'b0;
    end else begin
      sckQ      <= sck;
      wrenStb   <= 1'b0;
      wrdiStb   <= 1'b0;
      statWrStb <= 1'b0;
      memReq    <= 1'b0;
      memWe     <= 1'b0;
      if (!held && !holdN && !sck)     held <= 1'b1;
      else if (held && holdN && !sck)  held <= 1'b0;

      if (csN) begin
        phase     <= PH_OPC;
        bitCnt    <= '0;
        outActive <= 1'b0;
      end else begin
        if (rise) begin
          case (phase)
            PH_OPC: begin
              if (byteEnd) begin
                bitCnt <= '0;
                isRead <= (cmd == CMD_RD);
                if (busy && cmd != CMD_SRD) begin
                  phase <= PH_SKIP;
                end else begin
                  case (cmd)
                    CMD_RD, CMD_WR: phase <= PH_ADDR;
                    CMD_WEN: begin
                      wrenStb <= 1'b1;
                      phase   <= PH_SKIP;
                    end
                    CMD_WDIS: begin
                      wrdiStb <= 1'b1;
                      phase   <= PH_SKIP;
                    end
                    CMD_SRD: phase <= PH_SRD;
                    CMD_SWR: phase <= PH_SWR;
                    default: phase <= PH_SKIP;
                  endcase
                end
              end else begin
                bitCnt <= bitCnt + 4'd1;
              end
            end
            PH_ADDR: begin
              if (bitCnt == 4'd15) begin
                bitCnt <= '0;
                phase  <= isRead ? PH_RDATA : PH_WDATA;
                memReq <= isRead;
              end else begin
                bitCnt <= bitCnt + 4'd1;
              end
            end
            PH_WDATA: begin
              if (byteEnd) begin
                bitCnt <= '0;
                memReq <= 1'b1;
                memWe  <= 1'b1;
              end else begin
                bitCnt <= bitCnt + 4'd1;
              end
            end
            PH_SWR: begin
              if (byteEnd) begin
                statWrStb <= 1'b1;
                phase     <= PH_SKIP;
              end else begin
                bitCnt <= bitCnt + 4'd1;
              end
            end
            PH_RDATA, PH_SRD: bitCnt <= byteEnd ? 4'd0 : bitCnt + 4'd1;
            default: ;
          endcase
        end
        if (stb.outLoad) begin
          outActive <= 1'b1;
          if (phase == PH_RDATA) memReq <= 1'b1;
        end
      end
    end
  end

  AST_CMD_STROBE_IDLE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (wrenStb || wrdiStb) |-> $past(!busy)); // R11

  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({wrenStb, wrdiStb, statWrStb, memReq})); // R9

  AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    (held && !csN) |=> ($stable(bitCnt) && $stable(phase))); // R12

  AST_SKIP_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_SKIP) |=> !(memReq || wrenStb || wrdiStb || statWrStb || outActive)); // R3

endmodule

// File: rtl/spi_fe_dpath.sv
module spi_fe_dpath
  import spi_fe_pkg::*;
#(
  parameter int ADDR_BITS  = 13,
  parameter int PAGE_BYTES = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 si,
  input  strobe_t              stb,
  input  logic                 busy,
  input  logic [7:0]           statRdata,
  input  logic [7:0]           memRdata,
  input  logic                 memReq,
  input  logic                 memWe,
  output logic [7:0]           rxNext,
  output logic [ADDR_BITS-1:0] addr,
  output logic [7:0]           wrData,
  output logic                 soBit
);

  localparam int PAGE_BITS = $clog2(PAGE_BYTES);
  localparam logic [ADDR_BITS-1:0] PAGE_MASK = ADDR_BITS'((1 << PAGE_BITS) - 1);

  logic [7:0] rxShift;
  logic [7:0] nextByte;
  logic [7:0] outSh;
  logic       capQ;
  logic [ADDR_BITS-1:0] addrPlus;

  assign rxNext   = {rxShift[6:0], si};
  assign addrPlus = addr + ADDR_BITS'(1);
  assign soBit    = outSh[7];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift  <= '0;
      addr     <= '0;
      wrData   <= '0;
      nextByte <= '0;
      outSh    <= '0;
      capQ     <= 1'b0;
    end else begin
      if (stb.shiftIn) rxShift <= rxNext;
      if (stb.addrShift)      addr <= {addr[ADDR_BITS-2:0], si};
      else if (stb.addrIncRd) addr <= addrPlus;
      else if (stb.addrIncPg) addr <= (addr & ~PAGE_MASK) | (addrPlus & PAGE_MASK);
      if (stb.capWr) wrData <= rxNext;
      capQ <= memReq & ~memWe;
      if (capQ) nextByte <= memRdata;
      if (stb.outLoad)       outSh <= stb.srcStat ? (busy ? 8'hFF : statRdata) : nextByte;
      else if (stb.outShift) outSh <= {outSh[6:0], 1'b0};
    end
  end

endmodule

// File: rtl/spi_mem_frontend.sv
module spi_mem_frontend
  import spi_fe_pkg::*;
#(
  parameter int ADDR_BITS  = 13,
  parameter int PAGE_BYTES = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 csN,
  input  logic                 sck,
  input  logic                 si,
  input  logic                 holdN,
  output logic                 so,
  output logic                 soOe,
  input  logic                 busy,
  input  logic [7:0]           statRdata,
  output logic                 wrenStb,
  output logic                 wrdiStb,
  output logic                 statWrStb,
  output logic                 memReq,
  output logic                 memWe,
  output logic [ADDR_BITS-1:0] memAddr,
  output logic [7:0]           wrData,
  input  logic [7:0]           memRdata
);

  strobe_t    stb;
  logic [7:0] rxNext;
  logic       soBit;

  spi_fe_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .csN       (csN),
    .sck       (sck),
    .holdN     (holdN),
    .busy      (busy),
    .rxNext    (rxNext),
    .stb       (stb),
    .soOe      (soOe),
    .wrenStb   (wrenStb),
    .wrdiStb   (wrdiStb),
    .statWrStb (statWrStb),
    .memReq    (memReq),
    .memWe     (memWe)
  );

  spi_fe_dpath #(
    .ADDR_BITS  (ADDR_BITS),
    .PAGE_BYTES (PAGE_BYTES)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .si        (si),
    .stb       (stb),
    .busy      (busy),
    .statRdata (statRdata),
    .memRdata  (memRdata),
    .memReq    (memReq),
    .memWe     (memWe),
    .rxNext    (rxNext),
    .addr      (memAddr),
    .wrData    (wrData),
    .soBit     (soBit)
  );

  assign so = soOe ? soBit : 1'bz;

  AST_SO_ON_FALL: assert property (@(posedge clk) disable iff (!rstN)
    $stable(sck) |=> $stable(soBit)); // R6

endmodule

// File: tb/spi_mem_frontend_tb.sv
module spi_mem_frontend_tb;

  localparam int AW   = 6;
  localparam int PB   = 4;
  localparam int HALF = 5;
  localparam int MEMN = 1 << AW;

  logic clk = 1'b0, rstN = 1'b0, csN = 1'b1, sck = 1'b0, si = 1'b0, holdN = 1'b1, busy = 1'b0;
  logic [7:0] statRdata = 8'h8C;
  wire        so;
  logic soOe, wrenStb, wrdiStb, statWrStb, memReq, memWe;
  logic [AW-1:0] memAddr;
  logic [7:0] wrData, memRdata;

  logic [7:0] ram [0:MEMN-1];
  logic [7:0] expRam [0:MEMN-1];
  int checks = 0, fails = 0, evCount = 0;
  string curReq = "R1";
  logic oeSeen;
  bit done = 1'b0;

  typedef struct {int kind; int addr; int data; string req;} ev_t;
  ev_t evq[$];

  always #10 clk = ~clk;

  spi_mem_frontend #(.ADDR_BITS(AW), .PAGE_BYTES(PB)) u_dut (
    .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .si(si), .holdN(holdN),
    .so(so), .soOe(soOe), .busy(busy), .statRdata(statRdata),
    .wrenStb(wrenStb), .wrdiStb(wrdiStb), .statWrStb(statWrStb),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .wrData(wrData),
    .memRdata(memRdata)
  );

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < MEMN; i++) ram[i] <= 8'(i * 7 + 3);
      memRdata <= '0;
    end else if (memReq) begin
      if (memWe) ram[memAddr] <= wrData;
      memRdata <= ram[memAddr];
    end
  end

  task automatic chk(bit ok, string req, int act, int exp, string what);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic expectEv(int k, int a, int d, string req);
    ev_t e;
    e.kind = k; e.addr = a; e.data = d; e.req = req;
    evq.push_back(e);
  endtask

  task automatic seen(int k, int a, int d);
    ev_t e;
    evCount++;
    checks++;
    if (evq.size() == 0) begin
      fails++;
      $display("FAIL %s unexpected event kind %0d addr %0h data %0h, expected none", curReq, k, a, d);
    end else begin
      e = evq.pop_front();
      if (e.kind != k || e.addr != a || e.data != d) begin
        fails++;
        $display("FAIL %s event actual kind %0d addr %0h data %0h expected kind %0d addr %0h data %0h",
                 e.req, k, a, d, e.kind, e.addr, e.data);
      end
    end
  endtask

  // monitor: pops the scoreboard as the design produces actions
  always @(negedge clk) begin
    if (rstN) begin
      if (memReq && memWe) seen(0, int'(memAddr), int'(wrData));
      if (wrenStb)   seen(1, 0, 0);
      if (wrdiStb)   seen(2, 0, 0);
      if (statWrStb) seen(3, 0, int'(wrData));
    end
  end

  task automatic waitN(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx, input int holdAt);
    for (int i = 7; i >= 0; i--) begin
      si = tx[i];
      waitN(HALF);
      rx[i] = so;
      if (soOe) oeSeen = 1'b1;
      if (i == holdAt) begin
        holdN = 1'b0;
        waitN(3);
        chk(soOe == 1'b0, "R12", int'(soOe), 0, "output enable during hold");
        for (int j = 0; j < 3; j++) begin
          si = ~si; sck = 1'b1; waitN(2); sck = 1'b0; waitN(2);
        end
        si = tx[i];
        holdN = 1'b1;
        waitN(3);
      end
      sck = 1'b1;
      waitN(HALF);
      sck = 1'b0;
    end
  endtask

  task automatic csLow();
    csN = 1'b0;
    oeSeen = 1'b0;
    waitN(3);
  endtask

  task automatic csHigh();
    waitN(3);
    csN = 1'b1;
    waitN(4);
    chk(soOe == 1'b0, "R4", int'(soOe), 0, "output enable with chip select high");
  endtask

  task automatic cmdOnly(input logic [7:0] op);
    logic [7:0] r;
    csLow();
    xfer(op, r, -1);
    csHigh();
  endtask

  task automatic sendAddr(input logic [15:0] a16);
    logic [7:0] r;
    xfer(a16[15:8], r, -1);
    xfer(a16[7:0], r, -1);
  endtask

  task automatic doWrite(input logic [15:0] a16, int n, int d0, int holdByte);
    logic [7:0] r;
    int a;
    logic [7:0] d;
    csLow();
    xfer(8'h02, r, -1);
    sendAddr(a16);
    a = int'(a16) % MEMN;
    for (int i = 0; i < n; i++) begin
      d = 8'(d0 + i * 17);
      expectEv(0, a, int'(d), "R8");
      expRam[a] = d;
      xfer(d, r, (i == holdByte) ? 4 : -1);
      a = (a & ~(PB - 1)) | ((a + 1) & (PB - 1));
    end
    csHigh();
  endtask

  task automatic doRead(input logic [15:0] a16, int n, string req, int holdByte);
    logic [7:0] r;
    int a;
    csLow();
    xfer(8'h03, r, -1);
    sendAddr(a16);
    a = int'(a16) % MEMN;
    for (int i = 0; i < n; i++) begin
      xfer(8'hFF, r, (i == holdByte) ? 4 : -1);
      chk(r === expRam[a], req, int'(r), int'(expRam[a]), "read byte");
      a = (a + 1) % MEMN;
    end
    csHigh();
  endtask

  initial begin
    logic [7:0] r;
    int ev0;
    for (int i = 0; i < MEMN; i++) expRam[i] = 8'(i * 7 + 3);
    waitN(5);
    // R1: reset state
    chk(soOe == 1'b0, "R1", int'(soOe), 0, "output enable in reset");
    chk({memReq, wrenStb, wrdiStb, statWrStb} == 4'b0, "R1",
        int'({memReq, wrenStb, wrdiStb, statWrStb}), 0, "strobes in reset");
    rstN = 1'b1;
    waitN(5);
    chk(soOe == 1'b0 && memReq == 1'b0, "R1", int'({soOe, memReq}), 0, "idle after reset");

    curReq = "R9";
    expectEv(1, 0, 0, "R9");
    cmdOnly(8'h06);
    chk(evq.size() == 0, "R9", evq.size(), 0, "write-enable pulse");
    curReq = "R2";
    expectEv(1, 0, 0, "R2");
    cmdOnly(8'h0E);
    expectEv(2, 0, 0, "R2");
    cmdOnly(8'h0C);
    chk(evq.size() == 0, "R2", evq.size(), 0, "bit 3 ignored in decode");

    curReq = "R8";
    doWrite(16'hFFC2, 5, 'hA1, -1);
    curReq = "R5";
    doRead(16'hFF00, 4, "R5", -1);
    curReq = "R7";
    doRead(16'hA03E, 4, "R7", -1);
    curReq = "R6";
    doRead(16'h0005, 1, "R6", -1);

    curReq = "R13";
    ev0 = evCount;
    doRead(16'h0010, 2, "R13", -1);
    chk(evCount == ev0, "R13", evCount - ev0, 0, "actions during read data");

    curReq = "R3";
    ev0 = evCount;
    csLow();
    xfer(8'h07, r, -1);
    xfer(8'h06, r, -1);
    xfer(8'h02, r, -1);
    csHigh();
    chk(oeSeen == 1'b0, "R3", int'(oeSeen), 0, "output after bad code");
    csLow();
    xfer(8'h13, r, -1);
    xfer(8'h0E, r, -1);
    csHigh();
    chk(evCount == ev0, "R3", evCount - ev0, 0, "actions after bad code");
    expectEv(1, 0, 0, "R3");
    cmdOnly(8'h06);

    curReq = "R4";
    csLow();
    xfer(8'h03, r, -1);
    xfer(8'h00, r, -1);
    csHigh();
    expectEv(1, 0, 0, "R4");
    cmdOnly(8'h06);
    chk(evq.size() == 0, "R4", evq.size(), 0, "frame restarts at command");

    curReq = "R10";
    csLow();
    xfer(8'h05, r, -1);
    xfer(8'hFF, r, -1);
    chk(r === 8'h8C, "R10", int'(r), 'h8C, "status byte 1");
    xfer(8'hFF, r, -1);
    chk(r === 8'h8C, "R10", int'(r), 'h8C, "status byte 2");
    csHigh();
    expectEv(3, 0, 'h84, "R10");
    csLow();
    xfer(8'h01, r, -1);
    xfer(8'h84, r, -1);
    xfer(8'h55, r, -1);
    csHigh();

    curReq = "R11";
    busy = 1'b1;
    ev0 = evCount;
    cmdOnly(8'h06);
    csLow();
    xfer(8'h03, r, -1);
    sendAddr(16'h0000);
    xfer(8'hFF, r, -1);
    csHigh();
    chk(oeSeen == 1'b0, "R11", int'(oeSeen), 0, "read while busy");
    csLow();
    xfer(8'h05, r, -1);
    xfer(8'hFF, r, -1);
    csHigh();
    chk(r === 8'hFF, "R11", int'(r), 'hFF, "status while busy");
    chk(evCount == ev0, "R11", evCount - ev0, 0, "actions while busy");
    busy = 1'b0;

    curReq = "R12";
    doWrite(16'h0020, 2, 'h5A, 0);
    doRead(16'h0020, 2, "R12", 1);

    waitN(10);
    chk(evq.size() == 0, "R8", evq.size(), 0, "pending expected actions");
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL %s watchdog expired: actual running expected finished", curReq);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule